// File: doc/BRIEF.md
# Edge Interrupt Pulse Shaper

This block turns internal interrupt events into activity on one external interrupt line. In edge mode each event becomes a high pulse that lasts a programmable number of system clocks. Two pulses are kept apart by a minimum interval that is counted in start-of-frame ticks, one tick per 125 µs microframe. Events that arrive while a pulse is running, or before the interval has elapsed, are held and merged into a single later pulse. In level mode the line reports the pending state directly and is cleared by an acknowledge. The pulse timing and the interval have no effect in level mode.

A single 32-bit control word sets the timing. Its low half-word is the pulse width in clocks, and a width of zero selects a fixed 16-clock pulse. Its top byte is the interval in ticks. The byte in between is reserved. The block is meant to sit between an interrupt aggregator and the pin driver. The frame timer that produces the tick stays outside the block.

Top module: `irq_pulse_shaper`

## Requirements
- R1: While reset is asserted and right after it, `irq_o` is low and `cfg_rdata_o` reads 0x00000000.
- R2: Control word bits 15:0 hold the pulse width and bits 31:24 hold the interval. Bits 23:16 always read as zero, and writes to them are ignored. `cfg_rdata_o` shows the last written width and interval one clock after the write.
- R3: In edge mode, with no pulse running and the interval elapsed, an `evt_i` strobe makes `irq_o` rise on the second rising clock edge after the strobe cycle. The pulse then stays high for exactly the programmed number of clocks W (W ≥ 1).
- R4: A width field of zero gives a pulse of exactly 16 clocks.
- R5: After a pulse ends, no new pulse begins until G `sof_tick_i` strobes have been counted, where G is the interval field. A pending pulse rises on the second rising edge after the G-th tick.
- R6: With G = 0, an event that is pending when a pulse ends starts the next pulse after exactly one low clock.
- R7: Any number of events that arrive during a pulse or during its interval produce exactly one further pulse.
- R8: A width written while a pulse runs does not change that pulse. It applies from the next pulse.
- R9: In level mode, `irq_o` goes high one edge after an `evt_i` strobe and stays high, with no width applied, until an `ack_i` cycle without a strobe. It then goes low at the next edge. A strobe in the same cycle as `ack_i` keeps the line high.
- R10: In edge mode, `ack_i` has no effect: it neither shortens a pulse nor cancels a pending one.
- R11: In level mode the interval is ignored, so an event right after an acknowledge raises `irq_o` again with no ticks counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Interrupt event strobe |
| ack_i | input | 1 | Acknowledge; clears the pending state in level mode |
| sof_tick_i | input | 1 | One-clock strobe for each start-of-frame tick |
| level_mode_i | input | 1 | 1 = level mode, 0 = edge mode |
| cfg_wr_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word readback |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The assertions assume that `sof_tick_i` is a single-clock strobe. They also assume that `level_mode_i` changes only while nothing is pending, no pulse runs and the interval has elapsed, so every edge-to-level relation is taken with the mode held steady. The stimulus drives ticks only between pulses. It clears the pending state with an acknowledge and lets the interval run out before it switches modes. Each sweep entry adds ticks until the interval is fully drained, so every case starts from an idle state.

// File: rtl/irq_shaper_pkg.sv
package irq_shaper_pkg;

   localparam int unsigned IRQ_DATA_W        = 32;
   localparam int unsigned IRQ_WIDTH_W       = 16;
   localparam int unsigned IRQ_GAP_W         = 8;
   localparam int unsigned IRQ_DEFAULT_WIDTH = 16;

   typedef enum logic {
      OUT_EDGE  = 1'b0,
      OUT_LEVEL = 1'b1
   } irq_out_mode_e;

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WIDTH_W = 16,
   parameter int unsigned GAP_W   = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [DATA_W-1:0]  rd_data_o,
   output logic [WIDTH_W-1:0] width_o,
   output logic [GAP_W-1:0]   gap_o
);

   localparam int unsigned GAP_LSB = DATA_W - GAP_W;
   localparam int unsigned RSVD_W  = GAP_LSB - WIDTH_W;

   logic [WIDTH_W-1:0] width_q;
   logic [GAP_W-1:0]   gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         width_q <= '0;
         gap_q   <= '0;
      end else if (wr_en_i) begin
         width_q <= wr_data_i[WIDTH_W-1:0];
         gap_q   <= wr_data_i[DATA_W-1:GAP_LSB];
      end
   end

   // readback assembled bit by bit; bits between the fields are tied low
   for (genvar b = 0; b < DATA_W; b++) begin : g_rd_bit
      if (b < WIDTH_W) begin : g_width
         assign rd_data_o[b] = width_q[b];
      end else if (b >= GAP_LSB) begin : g_gap
         assign rd_data_o[b] = gap_q[b-GAP_LSB];
      end else begin : g_rsvd
         assign rd_data_o[b] = 1'b0;
      end
   end

   if (RSVD_W > 0) begin : g_rsvd_sink
      logic unused_rsvd_bits;
      assign unused_rsvd_bits = ^wr_data_i[GAP_LSB-1:WIDTH_W];
   end

   assign width_o = width_q;
   assign gap_o   = gap_q;

   if (RSVD_W > 0) begin : g_rsvd_check
      p_rsvd_zero_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         rd_data_o[GAP_LSB-1:WIDTH_W] == '0);
   end

   p_write_lands_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (width_o == $past(wr_data_i[WIDTH_W-1:0])) &&
                  (gap_o   == $past(wr_data_i[DATA_W-1:GAP_LSB])));

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
   parameter int unsigned WIDTH_W       = 16,
   parameter int unsigned DEFAULT_WIDTH = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [WIDTH_W-1:0] width_i,
   output logic               active_o,
   output logic               last_o
);

   localparam logic [WIDTH_W-1:0] DEF_W = WIDTH_W'(DEFAULT_WIDTH);

   logic [WIDTH_W-1:0] cnt_q;
   logic [WIDTH_W-1:0] load_val;

   // width is latched into the counter at launch, so later writes wait
   assign load_val = (width_i == '0) ? DEF_W : width_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i && (cnt_q == '0)) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);
   assign last_o   = (cnt_q == WIDTH_W'(1));

   p_count_down_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_zero_default_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !active_o && (width_i == '0)) |=> (cnt_q == DEF_W));

endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
   parameter int unsigned GAP_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [GAP_W-1:0] gap_i,
   input  logic             tick_i,
   output logic             open_o
);

   logic [GAP_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= gap_i;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign open_o = (cnt_q == '0);

   p_gap_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cnt_q != '0) && !tick_i && !load_i) |=> $stable(cnt_q));

   p_gap_step_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cnt_q != '0) && tick_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_pulse_shaper.sv
module irq_pulse_shaper #(
   parameter int unsigned DATA_W        = irq_shaper_pkg::IRQ_DATA_W,
   parameter int unsigned WIDTH_W       = irq_shaper_pkg::IRQ_WIDTH_W,
   parameter int unsigned GAP_W         = irq_shaper_pkg::IRQ_GAP_W,
   parameter int unsigned DEFAULT_WIDTH = irq_shaper_pkg::IRQ_DEFAULT_WIDTH
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              evt_i,
   input  logic              ack_i,
   input  logic              sof_tick_i,
   input  logic              level_mode_i,
   input  logic              cfg_wr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [DATA_W-1:0] cfg_rdata_o,
   output logic              irq_o
);
   import irq_shaper_pkg::*;

   if (WIDTH_W < 5 || GAP_W < 1) begin : g_bad_fields
      $error("irq_pulse_shaper: field widths too small");
   end
   if (WIDTH_W + GAP_W > DATA_W) begin : g_bad_layout
      $error("irq_pulse_shaper: fields overlap");
   end
   if (DEFAULT_WIDTH == 0 || DEFAULT_WIDTH >= (1 << WIDTH_W)) begin : g_bad_default
      $error("irq_pulse_shaper: default width out of range");
   end

   irq_out_mode_e      mode;
   logic [WIDTH_W-1:0] width_cfg;
   logic [GAP_W-1:0]   gap_cfg;
   logic               pend_q;
   logic               launch;
   logic               pulse_active;
   logic               pulse_last;
   logic               gap_open;

   assign mode = level_mode_i ? OUT_LEVEL : OUT_EDGE;

   irq_cfg_reg #(
      .DATA_W (DATA_W),
      .WIDTH_W(WIDTH_W),
      .GAP_W  (GAP_W)
   ) u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (cfg_wr_i),
      .wr_data_i(cfg_wdata_i),
      .rd_data_o(cfg_rdata_o),
      .width_o  (width_cfg),
      .gap_o    (gap_cfg)
   );

   // a pending event launches only when no pulse runs and the gap is over
   assign launch = (mode == OUT_EDGE) && pend_q && !pulse_active && gap_open;

   // a new strobe wins over a same-cycle clear, so no event is lost
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
      end else if (evt_i) begin
         pend_q <= 1'b1;
      end else if (launch) begin
         pend_q <= 1'b0;
      end else if ((mode == OUT_LEVEL) && ack_i) begin
         pend_q <= 1'b0;
      end
   end

   irq_pulse_timer #(
      .WIDTH_W      (WIDTH_W),
      .DEFAULT_WIDTH(DEFAULT_WIDTH)
   ) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (launch),
      .width_i (width_cfg),
      .active_o(pulse_active),
      .last_o  (pulse_last)
   );

   // gap starts counting on the edge that ends the pulse
   irq_gap_timer #(
      .GAP_W(GAP_W)
   ) u_gap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (pulse_last),
      .gap_i  (gap_cfg),
      .tick_i (sof_tick_i),
      .open_o (gap_open)
   );

   assign irq_o = (mode == OUT_LEVEL) ? pend_q : pulse_active;

   p_launch_gap_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pulse_active) |-> $past(gap_open));

   p_pulse_hold_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_active && !pulse_last) |=> pulse_active);

   p_level_ack_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_mode_i && ack_i && !evt_i && $stable(level_mode_i)) |=> !irq_o);

   p_level_set_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_mode_i && evt_i) |=> (irq_o || !level_mode_i));

   p_no_edge_in_level_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_mode_i |-> !launch);

endmodule

// File: tb/irq_pulse_shaper_bench.sv
module irq_pulse_shaper_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt = 1'b0;
   logic        ack = 1'b0;
   logic        sof = 1'b0;
   logic        lvl = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   irq_pulse_shaper u_irq_pulse_shaper (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .evt_i       (evt),
      .ack_i       (ack),
      .sof_tick_i  (sof),
      .level_mode_i(lvl),
      .cfg_wr_i    (wr),
      .cfg_wdata_i (wdata),
      .cfg_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_cfg(input logic [31:0] d);
      wr = 1'b1; wdata = d;
      step();
      wr = 1'b0;
   endtask

   task automatic fire();
      evt = 1'b1;
      step();
      evt = 1'b0;
   endtask

   task automatic tick();
      sof = 1'b1;
      step();
      sof = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int hi;
      int wl[5] = '{0, 1, 2, 5, 9};
      int gl[3] = '{0, 1, 3};

      // R1 reset state
      repeat (3) step();
      chk(irq == 1'b0, "R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      step();
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      chk(rdata == 32'h0, "R1 readback after reset", rdata, 0);

      // R2 layout and reserved byte
      write_cfg(32'hFFFF_FFFF);
      chk(rdata == 32'hFF00_FFFF, "R2 all ones", rdata, 32'hFF00_FFFF);
      write_cfg(32'h12AB_CDEF);
      chk(rdata == 32'h1200_CDEF, "R2 pattern", rdata, 32'h1200_CDEF);

      // R3..R7 sweep over widths and gaps; bench arms events during pulse and gap
      write_cfg(32'h0);
      repeat (2) tick();
      foreach (wl[i]) begin
         foreach (gl[j]) begin
            int w_eff;
            w_eff = (wl[i] == 0) ? 16 : wl[i];
            write_cfg((32'(gl[j]) << 24) | 32'(wl[i]));
            fire();
            chk(irq == 1'b0, "R3 low on first edge", irq, 0);
            step();
            chk(irq == 1'b1, "R3 rise on second edge", irq, 1);
            hi = 0;
            while (irq && hi < 100) begin
               hi++;
               evt = (hi <= 2);
               step();
            end
            evt = 1'b0;
            chk(hi == w_eff, (wl[i] == 0) ? "R4 default width" : "R3 width", hi, w_eff);
            if (gl[j] == 0) begin
               step();
               chk(irq == 1'b1, "R6 one low clock", irq, 1);
            end else begin
               for (int k = 0; k < 3; k++) begin
                  evt = (k == 0);
                  step();
                  evt = 1'b0;
                  chk(irq == 1'b0, "R5 wait without ticks", irq, 0);
               end
               for (int t = 1; t <= gl[j]; t++) begin
                  tick();
                  chk(irq == 1'b0, "R5 low while ticks counted", irq, 0);
               end
               step();
               chk(irq == 1'b1, "R5 rise after last tick", irq, 1);
            end
            hi = 0;
            while (irq && hi < 100) begin
               hi++;
               step();
            end
            chk(hi == w_eff, "R7 merged pulse width", hi, w_eff);
            for (int t = 0; t < gl[j]; t++) tick();
            hi = 0;
            for (int k = 0; k < 6; k++) begin
               step();
               if (irq) hi++;
            end
            chk(hi == 0, "R7 no extra pulse", hi, 0);
         end
      end

      // R8 write during a pulse
      write_cfg(32'h0000_0006);
      fire();
      step();
      hi = 0;
      while (irq && hi < 100) begin
         hi++;
         wr = (hi == 2); wdata = 32'h0000_0003;
         step();
         wr = 1'b0;
      end
      chk(hi == 6, "R8 running pulse keeps width", hi, 6);
      chk(rdata == 32'h3, "R8 new width stored", rdata, 3);
      step();
      fire();
      step();
      hi = 0;
      while (irq && hi < 100) begin hi++; step(); end
      chk(hi == 3, "R8 next pulse uses new width", hi, 3);

      // R10 acknowledge in edge mode
      write_cfg(32'h0200_0008);
      fire();
      step();
      hi = 0;
      while (irq && hi < 100) begin
         hi++;
         ack = 1'b1;
         evt = (hi == 1);
         step();
         evt = 1'b0;
      end
      chk(hi == 8, "R10 ack does not shorten", hi, 8);
      step();
      ack = 1'b0;
      tick();
      tick();
      step();
      chk(irq == 1'b1, "R10 ack does not cancel pending", irq, 1);
      hi = 0;
      while (irq && hi < 100) begin hi++; step(); end
      chk(hi == 8, "R10 pending pulse width", hi, 8);
      tick();
      tick();
      step();

      // R9 / R11 level mode
      write_cfg(32'h0500_0002);
      lvl = 1'b1;
      step();
      chk(irq == 1'b0, "R9 idle level", irq, 0);
      fire();
      chk(irq == 1'b1, "R9 level rise", irq, 1);
      repeat (30) step();
      chk(irq == 1'b1, "R9 held without width", irq, 1);
      ack = 1'b1;
      step();
      ack = 1'b0;
      chk(irq == 1'b0, "R9 ack clears", irq, 0);
      fire();
      chk(irq == 1'b1, "R11 no gap in level mode", irq, 1);
      ack = 1'b1; evt = 1'b1;
      step();
      ack = 1'b0; evt = 1'b0;
      chk(irq == 1'b1, "R9 strobe beats ack", irq, 1);
      ack = 1'b1;
      step();
      ack = 1'b0;
      chk(irq == 1'b0, "R9 final clear", irq, 0);
      lvl = 1'b0;
      step();
      chk(irq == 1'b0, "R9 back to edge quiet", irq, 0);

      finish_run();
   end

endmodule